// File: doc/BRIEF.md
# Integer Execute Unit with Iterative Divider

This block is the arithmetic and logic execute stage of a 32-bit core. Each cycle it receives an operation code, two register operands, a 16-bit instruction immediate, a 5-bit shift amount and a destination register index. It returns a 32-bit result, a write enable and the destination index to write. It covers addition, subtraction, bitwise logic, shifts and rotates, set-on-compare, low-half and high-half multiplication, and signed and unsigned division.

Every operation except division completes combinationally in the cycle it is presented. A division request starts an engine that retires one quotient bit per cycle and finishes with a sign fix-up cycle. The engine shows `busy` while it works. When it finishes, it raises `done` for one cycle and presents the quotient and its captured destination on the result port. The register file, hazard handling and exceptions belong to the neighbouring stages.

Top module: `int_exec_unit`

## Requirements
- R1: Register forms ADD, SUB, AND, OR, XOR and NOR combine `opnd_a` with `opnd_b` modulo 2^32; NOR returns the inverted OR.
- R2: ADDI, MULI and the signed immediate compares (CMPGEI, CMPLTI, CMPNEI, CMPEQI) use `imm16` sign-extended. ANDI, ORI, XORI, CMPGEUI and CMPLTUI use `imm16` zero-extended.
- R3: ANDHI, ORHI and XORHI place `imm16` in bits 31:16 with zeros below, then apply AND, OR or XOR to `opnd_a`.
- R4: SLL, SRL, SRA, ROL and ROR take their amount from `opnd_b[4:0]` only. SLLI, SRLI, SRAI and ROLI take it from `shamt`. A rotate by 0 returns the operand unchanged.
- R5: The compares (GE, LT, NE, EQ, GEU, LTU and their immediate forms) write 1 when the relation of A to the second operand holds, and 0 otherwise.
- R6: MUL and MULI return the low 32 bits of the product. MULXSS, MULXUU and MULXSU return bits 63:32 of the 64-bit product, with A×B treated as signed×signed, unsigned×unsigned and signed×unsigned respectively.
- R7: DIV returns the signed quotient truncated toward zero. A zero divisor, or a dividend of 0x80000000 with divisor 0xFFFFFFFF, is replaced by divisor 1.
- R8: DIVU returns the unsigned quotient. A zero divisor is replaced by 1, so the result equals the dividend.
- R9: After reset `busy` and `done` are 0. A division accepted at a clock edge makes `busy` 1 from that edge, and `done` rises at the 33rd following edge.
- R10: `busy` and `done` are never high together, and `done` lasts one cycle. A division request made while `busy` is 1 is ignored.
- R11: `wr_en` is 0 when the destination index is 0 or when `op_valid` is 0.
- R12: Non-divide operations drive `result`, `wr_en` and `wr_dest` in the same cycle, with no clock edge in between.
- R13: A division request itself produces no write. The quotient is written in the `done` cycle to the destination captured at the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Operation select (package enumeration) |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| imm16 | input | 16 | Instruction immediate |
| shamt | input | 5 | Immediate shift amount |
| dest_idx | input | 5 | Destination register index |
| result | output | 32 | Result value |
| wr_en | output | 1 | Write the result to `wr_dest` |
| wr_dest | output | 5 | Register index to write |
| busy | output | 1 | Division engine is working |
| done | output | 1 | Division quotient is on `result` this cycle |

## Verification
The combinational paths hold no state, so a fault in the extension, shift or compare decode shows on `result` in the same cycle as the faulty operand. A wrong divider state is harder to see. A miscounted iteration shifts the `done` edge away from exactly 33 edges after acceptance. A lost sign flag or a wrong divisor substitution corrupts only the single-cycle quotient. A leak of a request made while busy replaces the expected quotient or destination. Each of these becomes visible within 34 cycles of the request.

// File: rtl/ix_pkg.sv
// Shared operation codes and decode helpers for the integer execute unit.
// Assumes a 6-bit operation field; codes above OP_DIVU produce no result.
package ix_pkg;
    localparam int XLEN      = 32;
    localparam int IMM_W     = 16;
    localparam int REG_IDX_W = 5;
    localparam int OP_W      = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 6'd0, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_ADDI, OP_ANDI, OP_ORI, OP_XORI, OP_ANDHI, OP_ORHI, OP_XORHI,
        OP_MULI, OP_MUL, OP_MULXSS, OP_MULXUU, OP_MULXSU,
        OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
        OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI,
        OP_CMPGE, OP_CMPLT, OP_CMPNE, OP_CMPEQ, OP_CMPGEU, OP_CMPLTU,
        OP_CMPGEI, OP_CMPLTI, OP_CMPNEI, OP_CMPEQI, OP_CMPGEUI, OP_CMPLTUI,
        OP_DIV, OP_DIVU
    } op_e;

    typedef enum logic [1:0] {EXT_NONE, EXT_SIGN, EXT_ZERO, EXT_HIGH} ext_e;
    typedef enum logic [1:0] {DV_IDLE, DV_RUN, DV_FIX} dv_state_e;

    // How the immediate forms the second operand
    function automatic ext_e ext_mode(op_e op);
        case (op)
            OP_ADDI, OP_MULI, OP_CMPGEI, OP_CMPLTI, OP_CMPNEI, OP_CMPEQI: return EXT_SIGN;
            OP_ANDI, OP_ORI, OP_XORI, OP_CMPGEUI, OP_CMPLTUI:             return EXT_ZERO;
            OP_ANDHI, OP_ORHI, OP_XORHI:                                  return EXT_HIGH;
            default:                                                      return EXT_NONE;
        endcase
    endfunction

    function automatic logic is_div(op_e op);
        return (op == OP_DIV) || (op == OP_DIVU);
    endfunction

    function automatic logic is_mul(op_e op);
        return (op == OP_MUL) || (op == OP_MULI) || (op == OP_MULXSS) ||
               (op == OP_MULXUU) || (op == OP_MULXSU);
    endfunction
endpackage

// File: rtl/ix_alu.sv
// Combinational add/sub, logic, shift/rotate and compare datapath.
// Assumes the second operand b is already selected (register or extended immediate).
module ix_alu
    import ix_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  op_e             op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [SH_W-1:0] sh_imm,
    output logic [W-1:0]    y
);
    localparam logic [SH_W:0] WIDE = (SH_W+1)'(W);

    logic [SH_W-1:0] sh;
    logic [W-1:0]    rotl, rotr;
    logic            lt_s, lt_u, eq;

    // Pick the shift amount: instruction field for immediate forms, low bits of b otherwise
    always_comb begin
        if (op == OP_SLLI || op == OP_SRLI || op == OP_SRAI || op == OP_ROLI) sh = sh_imm;
        else                                                                 sh = b[SH_W-1:0];
    end

    // Rotates and comparison flags
    always_comb begin
        rotl = (a << sh) | (a >> (WIDE - {1'b0, sh}));
        rotr = (a >> sh) | (a << (WIDE - {1'b0, sh}));
        lt_s = $signed(a) < $signed(b);
        lt_u = a < b;
        eq   = (a == b);
    end

    // Result select by operation
    always_comb begin
        case (op)
            OP_ADD, OP_ADDI:                    y = a + b;
            OP_SUB:                             y = a - b;
            OP_AND, OP_ANDI, OP_ANDHI:          y = a & b;
            OP_OR,  OP_ORI,  OP_ORHI:           y = a | b;
            OP_XOR, OP_XORI, OP_XORHI:          y = a ^ b;
            OP_NOR:                             y = ~(a | b);
            OP_SLL, OP_SLLI:                    y = a << sh;
            OP_SRL, OP_SRLI:                    y = a >> sh;
            OP_SRA, OP_SRAI:                    y = $unsigned($signed(a) >>> sh);
            OP_ROL, OP_ROLI:                    y = rotl;
            OP_ROR:                             y = rotr;
            OP_CMPGE,  OP_CMPGEI:               y = W'(!lt_s);
            OP_CMPLT,  OP_CMPLTI:               y = W'(lt_s);
            OP_CMPNE,  OP_CMPNEI:               y = W'(!eq);
            OP_CMPEQ,  OP_CMPEQI:               y = W'(eq);
            OP_CMPGEU, OP_CMPGEUI:              y = W'(!lt_u);
            OP_CMPLTU, OP_CMPLTUI:              y = W'(lt_u);
            default:                            y = '0;
        endcase
    end
endmodule

// File: rtl/ix_mul.sv
// Single shared multiplier giving the low or high word of a 2W-bit product.
// Assumes signedness flags per operand; low word is signedness-independent.
module ix_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn_a,
    input  logic         sgn_b,
    input  logic         sel_hi,
    output logic [W-1:0] y
);
    logic [2*W-1:0] ea, eb, prod;

    // Extend each operand to 2W bits and keep the product modulo 2^(2W)
    always_comb begin
        ea   = {{W{sgn_a & a[W-1]}}, a};
        eb   = {{W{sgn_b & b[W-1]}}, b};
        prod = ea * eb;
        y    = sel_hi ? prod[2*W-1:W] : prod[W-1:0];
    end
endmodule

// File: rtl/ix_div.sv
// Restoring divider: one quotient bit per cycle over W cycles, then one sign fix-up cycle.
// Assumes start is only honoured while idle; the divisor is forced to 1 for the
// zero and signed-overflow cases before iteration begins.
module ix_div
    import ix_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sgn,
    input  logic [W-1:0]     dividend,
    input  logic [W-1:0]     divisor,
    input  logic [TAG_W-1:0] tag_in,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     q_out,
    output logic [TAG_W-1:0] tag_out
);
    localparam int              CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
    localparam logic [W-1:0]     MINV = {1'b1, {(W-1){1'b0}}};

    dv_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]   rem, quo, dvs, dvs_fix, mag_a, mag_b;
    logic [W:0]     rem_sh, diff;
    logic           neg, neg_n;
    logic [W-1:0]   chk_a;
    logic           chk_zero_u;

    // Divisor substitution and operand magnitudes at request time
    always_comb begin
        dvs_fix = ((divisor == '0) || (sgn && dividend == MINV && divisor == '1)) ? W'(1) : divisor;
        mag_a   = (sgn && dividend[W-1]) ? -dividend : dividend;
        mag_b   = (sgn && dvs_fix[W-1])  ? -dvs_fix  : dvs_fix;
        neg_n   = sgn && (dividend[W-1] ^ dvs_fix[W-1]);
    end

    // One restoring step: shift in the next dividend bit and trial-subtract
    always_comb begin
        rem_sh = {rem, quo[W-1]};
        diff   = rem_sh - {1'b0, dvs};
    end

    assign busy = (st != DV_IDLE);

    // Engine sequencing: idle -> W iterations -> sign fix-up with done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= DV_IDLE; cnt <= '0; rem <= '0; quo <= '0; dvs <= '0; neg <= 1'b0;
            done <= 1'b0; q_out <= '0; tag_out <= '0; chk_a <= '0; chk_zero_u <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                DV_IDLE: if (start) begin
                    st <= DV_RUN; cnt <= '0; rem <= '0; quo <= mag_a; dvs <= mag_b;
                    neg <= neg_n; tag_out <= tag_in;
                    chk_a <= dividend; chk_zero_u <= !sgn && (divisor == '0);
                end
                DV_RUN: begin
                    rem <= diff[W] ? rem_sh[W-1:0] : diff[W-1:0];
                    quo <= {quo[W-2:0], ~diff[W]};
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) st <= DV_FIX;
                end
                DV_FIX: begin
                    q_out <= neg ? -quo : quo;
                    done  <= 1'b1;
                    st    <= DV_IDLE;
                end
                default: st <= DV_IDLE;
            endcase
        end
    end

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R8
    divzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_zero_u) |-> (q_out == chk_a));
endmodule

// File: rtl/int_exec_unit.sv
// Integer execute stage: combinational ALU and multiplier, iterative divider.
// Assumes the issuing stage holds off dependent work while busy; results for
// register 0 are never written.
module int_exec_unit
    import ix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      op_code,
    input  logic [XLEN-1:0]      opnd_a,
    input  logic [XLEN-1:0]      opnd_b,
    input  logic [IMM_W-1:0]     imm16,
    input  logic [4:0]           shamt,
    input  logic [REG_IDX_W-1:0] dest_idx,
    output logic [XLEN-1:0]      result,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] wr_dest,
    output logic                 busy,
    output logic                 done
);
    op_e                  op;
    logic [XLEN-1:0]      opnd2, alu_y, mul_y, div_q;
    logic                 div_req, div_start, m_sa, m_sb, m_hi;
    logic [REG_IDX_W-1:0] div_tag;

    assign op        = op_e'(op_code);
    assign div_req   = op_valid && is_div(op);
    assign div_start = div_req && !busy;

    // Second operand: register B or the immediate in one of three extensions
    always_comb begin
        case (ext_mode(op))
            EXT_SIGN: opnd2 = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
            EXT_ZERO: opnd2 = {{(XLEN-IMM_W){1'b0}}, imm16};
            EXT_HIGH: opnd2 = {imm16, {(XLEN-IMM_W){1'b0}}};
            default:  opnd2 = opnd_b;
        endcase
    end

    // Multiplier signedness and word select
    always_comb begin
        m_sa = (op == OP_MULXSS) || (op == OP_MULXSU);
        m_sb = (op == OP_MULXSS);
        m_hi = (op == OP_MULXSS) || (op == OP_MULXUU) || (op == OP_MULXSU);
    end

    ix_alu #(.W(XLEN)) u_alu (
        .op(op), .a(opnd_a), .b(opnd2), .sh_imm(shamt), .y(alu_y)
    );

    ix_mul #(.W(XLEN)) u_mul (
        .a(opnd_a), .b(opnd2), .sgn_a(m_sa), .sgn_b(m_sb), .sel_hi(m_hi), .y(mul_y)
    );

    ix_div #(.W(XLEN), .TAG_W(REG_IDX_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .sgn(op == OP_DIV),
        .dividend(opnd_a), .divisor(opnd_b), .tag_in(dest_idx),
        .busy(busy), .done(done), .q_out(div_q), .tag_out(div_tag)
    );

    // Output select: a finished quotient takes the port over the combinational path
    always_comb begin
        if (done) begin
            result  = div_q;
            wr_dest = div_tag;
            wr_en   = (div_tag != '0);
        end else begin
            result  = is_mul(op) ? mul_y : alu_y;
            wr_dest = dest_idx;
            wr_en   = op_valid && !is_div(op) && (dest_idx != '0);
        end
    end

    // R11
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_dest != '0));
    // R13
    div_req_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_req && !done) |-> !wr_en);
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
    import ix_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm16 = '0;
    logic [4:0]  shamt = '0, dest_idx = '0;
    logic [31:0] result;
    logic        wr_en, busy, done;
    logic [4:0]  wr_dest;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;  // 125 MHz

    int_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .shamt(shamt),
        .dest_idx(dest_idx), .result(result), .wr_en(wr_en), .wr_dest(wr_dest),
        .busy(busy), .done(done)
    );

    typedef struct packed {
        op_e         op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [4:0]  sh;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{OP_ADD,    32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'h0000000C, 8'd1}, // R1
        '{OP_SUB,    32'h00000003, 32'h00000005, 16'h0000, 5'd0,  32'hFFFFFFFE, 8'd1}, // R1
        '{OP_AND,    32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 5'd0,  32'hF000F000, 8'd1}, // R1
        '{OP_OR,     32'h0F0F0000, 32'h000000FF, 16'h0000, 5'd0,  32'h0F0F00FF, 8'd1}, // R1
        '{OP_XOR,    32'hFFFF0000, 32'h0F0F0F0F, 16'h0000, 5'd0,  32'hF0F00F0F, 8'd1}, // R1
        '{OP_NOR,    32'h0F0F0F0F, 32'h00FF00FF, 16'h0000, 5'd0,  32'hF000F000, 8'd1}, // R1
        '{OP_ADDI,   32'h0000000A, 32'h12345678, 16'hFFFF, 5'd0,  32'h00000009, 8'd2}, // R2
        '{OP_ANDI,   32'hFFFFFFFF, 32'h0,        16'h8001, 5'd0,  32'h00008001, 8'd2}, // R2
        '{OP_ORI,    32'h00000000, 32'hFFFFFFFF, 16'h8000, 5'd0,  32'h00008000, 8'd2}, // R2
        '{OP_XORI,   32'hFFFFFFFF, 32'h0,        16'hFFFF, 5'd0,  32'hFFFF0000, 8'd2}, // R2
        '{OP_MULI,   32'h00000003, 32'h0,        16'hFFFE, 5'd0,  32'hFFFFFFFA, 8'd2}, // R2
        '{OP_CMPLTI, 32'hFFFFFFFE, 32'h0,        16'hFFFF, 5'd0,  32'h00000001, 8'd2}, // R2
        '{OP_CMPGEI, 32'hFFFFFFFE, 32'h0,        16'hFFFF, 5'd0,  32'h00000000, 8'd2}, // R2
        '{OP_CMPLTUI,32'h00010000, 32'h0,        16'h8000, 5'd0,  32'h00000000, 8'd2}, // R2
        '{OP_CMPGEUI,32'h00010000, 32'h0,        16'h8000, 5'd0,  32'h00000001, 8'd2}, // R2
        '{OP_CMPEQI, 32'hFFFFFFFF, 32'h0,        16'hFFFF, 5'd0,  32'h00000001, 8'd2}, // R2
        '{OP_CMPNEI, 32'hFFFFFFFF, 32'h0,        16'hFFFF, 5'd0,  32'h00000000, 8'd2}, // R2
        '{OP_ANDHI,  32'h12345678, 32'h0,        16'hFF00, 5'd0,  32'h12000000, 8'd3}, // R3
        '{OP_ORHI,   32'h00001234, 32'h0,        16'hABCD, 5'd0,  32'hABCD1234, 8'd3}, // R3
        '{OP_XORHI,  32'hFFFFFFFF, 32'h0,        16'h00FF, 5'd0,  32'hFF00FFFF, 8'd3}, // R3
        '{OP_SLL,    32'h00000001, 32'h00000024, 16'h0000, 5'd9,  32'h00000010, 8'd4}, // R4
        '{OP_SRL,    32'h80000000, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'h00000001, 8'd4}, // R4
        '{OP_SRA,    32'h80000000, 32'h00000004, 16'h0000, 5'd0,  32'hF8000000, 8'd4}, // R4
        '{OP_ROL,    32'h80000001, 32'h00000001, 16'h0000, 5'd0,  32'h00000003, 8'd4}, // R4
        '{OP_ROR,    32'h80000001, 32'h00000021, 16'h0000, 5'd0,  32'hC0000000, 8'd4}, // R4
        '{OP_ROL,    32'hDEADBEEF, 32'h00000020, 16'h0000, 5'd0,  32'hDEADBEEF, 8'd4}, // R4
        '{OP_ROR,    32'hDEADBEEF, 32'h00000000, 16'h0000, 5'd0,  32'hDEADBEEF, 8'd4}, // R4
        '{OP_SLLI,   32'h00000003, 32'h0000FFFF, 16'h0000, 5'd2,  32'h0000000C, 8'd4}, // R4
        '{OP_SRAI,   32'hF0000000, 32'h00000001, 16'h0000, 5'd4,  32'hFF000000, 8'd4}, // R4
        '{OP_SRLI,   32'hF0000000, 32'h00000000, 16'h0000, 5'd28, 32'h0000000F, 8'd4}, // R4
        '{OP_ROLI,   32'h12345678, 32'h00000000, 16'h0000, 5'd8,  32'h34567812, 8'd4}, // R4
        '{OP_CMPGE,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000, 8'd5}, // R5
        '{OP_CMPLT,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001, 8'd5}, // R5
        '{OP_CMPGEU, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001, 8'd5}, // R5
        '{OP_CMPLTU, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000, 8'd5}, // R5
        '{OP_CMPEQ,  32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000001, 8'd5}, // R5
        '{OP_CMPNE,  32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000, 8'd5}, // R5
        '{OP_CMPGE,  32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000001, 8'd5}, // R5
        '{OP_MUL,    32'hFFFFFFFF, 32'h00000002, 16'h0000, 5'd0,  32'hFFFFFFFE, 8'd6}, // R6
        '{OP_MULXSS, 32'hFFFFFFFF, 32'h00000002, 16'h0000, 5'd0,  32'hFFFFFFFF, 8'd6}, // R6
        '{OP_MULXUU, 32'hFFFFFFFF, 32'h00000002, 16'h0000, 5'd0,  32'h00000001, 8'd6}, // R6
        '{OP_MULXSU, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'hFFFFFFFF, 8'd6}, // R6
        '{OP_MULXUU, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'hFFFFFFFE, 8'd6}, // R6
        '{OP_MULXSS, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'h00000000, 8'd6}, // R6
        '{OP_MULXSS, 32'h80000000, 32'h80000000, 16'h0000, 5'd0,  32'h40000000, 8'd6}, // R6
        '{OP_MULXSU, 32'h00000002, 32'h80000000, 16'h0000, 5'd0,  32'h00000001, 8'd6}  // R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one division, track latency and check the quotient write
    task automatic run_div(input op_e op, input logic [31:0] a, input logic [31:0] b,
                           input logic [4:0] dest, input logic [31:0] exp,
                           input bit interfere, input string tag);
        int lat;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; dest_idx = dest;
        #1 chk({tag, " R13 no write on request"}, 32'(wr_en), 32'd0);
        @(negedge clk);
        if (interfere) begin
            op_code = OP_DIVU; opnd_a = 32'h55; opnd_b = 32'h1; dest_idx = 5'd7;
        end else begin
            op_valid = 1'b0;
        end
        chk({tag, " R9 busy after accept"}, 32'(busy), 32'd1);
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            op_valid = 1'b0;
            lat++;
        end
        chk({tag, " R9 latency"}, 32'(lat), 32'd33);
        chk({tag, " R10 busy low at done"}, 32'(busy), 32'd0);
        chk({tag, " quotient"}, result, exp);
        chk({tag, " R13 wr_en at done"}, 32'(wr_en), 32'(dest != 5'd0));
        chk({tag, " R13 wr_dest"}, 32'(wr_dest), 32'(dest));
        @(negedge clk);
        chk({tag, " R10 done single cycle"}, 32'(done), 32'd0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R9 reset done", 32'(done), 32'd0);
        chk("R11 idle wr_en", 32'(wr_en), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = VEC[i].op; opnd_a = VEC[i].a; opnd_b = VEC[i].b;
            imm16 = VEC[i].imm; shamt = VEC[i].sh; dest_idx = 5'd3;
            #2;
            chk($sformatf("R%0d vector %0d result", VEC[i].rq, i), result, VEC[i].exp);
            chk($sformatf("R12 vector %0d wr_en", i), 32'({wr_en, wr_dest}), 32'({1'b1, 5'd3}));
        end

        // R12: output follows a mid-cycle operand change with no edge between
        @(negedge clk);
        op_code = OP_ADD; opnd_a = 32'd1; opnd_b = 32'd1; dest_idx = 5'd4;
        #1 chk("R12 first value", result, 32'd2);
        opnd_b = 32'd9;
        #1 chk("R12 same-cycle update", result, 32'd10);

        // R11: destination 0 and invalid operation never write
        dest_idx = 5'd0;
        #1 chk("R11 dest zero wr_en", 32'(wr_en), 32'd0);
        dest_idx = 5'd4; op_valid = 1'b0;
        #1 chk("R11 op_valid low wr_en", 32'(wr_en), 32'd0);

        run_div(OP_DIV,  32'd100,       32'd7,        5'd5,  32'd14,        1'b0, "R7 pos/pos");
        run_div(OP_DIV,  32'hFFFFFF9C,  32'd7,        5'd6,  32'hFFFFFFF2,  1'b0, "R7 neg/pos");
        run_div(OP_DIV,  32'd100,       32'hFFFFFFF9, 5'd8,  32'hFFFFFFF2,  1'b0, "R7 pos/neg");
        run_div(OP_DIV,  32'hFFFFFF9C,  32'hFFFFFFF9, 5'd9,  32'd14,        1'b0, "R7 neg/neg");
        run_div(OP_DIV,  32'hFFFFFF9C,  32'd0,        5'd10, 32'hFFFFFF9C,  1'b0, "R7 by zero");
        run_div(OP_DIV,  32'h80000000,  32'hFFFFFFFF, 5'd11, 32'h80000000,  1'b0, "R7 overflow");
        run_div(OP_DIVU, 32'hFFFFFFFF,  32'd0,        5'd12, 32'hFFFFFFFF,  1'b0, "R8 by zero");
        run_div(OP_DIVU, 32'hFFFFFFFF,  32'd2,        5'd13, 32'h7FFFFFFF,  1'b0, "R8 large");
        run_div(OP_DIV,  32'd1000,      32'd10,       5'd14, 32'd100,       1'b1, "R10 request while busy");
        run_div(OP_DIVU, 32'd50,        32'd5,        5'd0,  32'd10,        1'b0, "R11 divide to r0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule